// File: doc/BRIEF.md
# Receive Call Acceptance Controller

This block sits on the receive side of a digital voice/data radio modem and decides whether an incoming transmission is a call for this station. After the host selects receive mode, it waits for a frame-sync pulse. It then examines the control channel of the first frame that arrives with a good check result. The received 6-bit radio access number (RAN) is compared against six host-programmed values and against the all-zeros broadcast value. An open-receive override accepts every call regardless of the address.

An accepted call raises a one-cycle "called" interrupt and records the kind of match. Decoded blocks then pass to the host through a holding register, each one flagged by a level data-ready interrupt. Blocks that failed their check also pulse an event interrupt and load an error code. In soft-data mode a payload word is handed over as four 4-bit log-likelihood values on four consecutive cycles. The call ends on an end-frame indication, after too many consecutive control-channel failures, or when the host returns the mode to idle. After the last block has been collected, the block commands a new sync search without any host action.

Top module: `rx_call_ctrl`

## Requirements
- R1: While `rstN` is low, and on the clock after `modeRx` goes low, `searching`, `callActive`, `irqDataReady`, `irqCalled` and `overrun` are 0. On the first clock with `modeRx` high from idle, `searching` becomes 1 and `restartSearch` pulses for exactly one cycle.
- R2: While searching, a `syncPulse` moves the block into first-frame checking, where `searching` and `callActive` are both 0.
- R3: During first-frame checking, a control-channel result with `ctrlCrcOk` low is ignored, whatever address it carries. The block keeps waiting for a later frame with a good control channel.
- R4: A good control channel whose `rxAddr` equals any entry i of `ownAddrs` is accepted. Entry i occupies bits [6i+5:6i]. Acceptance sets `callActive`, pulses `irqCalled` for one cycle, and sets `matchCode` to 01 (exact).
- R5: A good control channel with `rxAddr` all zeros is accepted with `matchCode` 10 (broadcast). Broadcast takes priority over an exact hit.
- R6: A good control channel with no address hit is handled according to `openRx`. With `openRx` low, the call is rejected, `searching` returns to 1 and `restartSearch` pulses. With `openRx` high, the call is accepted with `matchCode` 00.
- R7: During a call, a `blkValid` loads `blkType` and `blkData` into `holdType`/`holdData` and sets `irqDataReady`. `irqDataReady` stays set until a cycle with `hostAck` high and no new delivery.
- R8: A delivered block with `blkCrcOk` low pulses `irqEvent` for one cycle, together with `irqDataReady`. It also loads `errCode`: 01 for a payload block (`blkType` 4), 10 for any other type.
- R9: A delivery while `irqDataReady` is set and `hostAck` is low sets `overrun`. The new block still overwrites the holding register. `overrun` stays set until the mode goes idle.
- R10: With `softMode` high, a payload block (`blkType` 4) is delivered as four 4-bit values on four consecutive cycles, low nibble first. Each value is zero-extended in `holdData` and each sets `irqDataReady`. Other block types are delivered whole.
- R11: During a call, each control-channel result with `ctrlCrcOk` low adds one to a drop count, and a good result clears the count. The failure that would take the count past `dropLimit` ends the call.
- R12: An `endFrame`, or the end of a call under R11, leads to a flush. Blocks are still delivered during the flush. Once no data-ready is pending and no split is in progress, `callActive` falls, `searching` rises and `restartSearch` pulses.
- R13: From any state, `modeRx` low returns the block to idle on the next clock and clears pending data-ready and the stored error, match and overrun state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeRx | input | 1 | 1 = receive mode, 0 = idle |
| openRx | input | 1 | Accept every call regardless of address |
| softMode | input | 1 | Deliver payload as 4-bit soft values |
| ownAddrs | input | 36 | Six programmed 6-bit addresses, entry i at [6i+5:6i] |
| dropLimit | input | 4 | Allowed consecutive control-channel failures |
| syncPulse | input | 1 | Frame-sync detected |
| ctrlValid | input | 1 | Control-channel result for a frame is present |
| ctrlCrcOk | input | 1 | Control channel passed its CRC/parity check |
| rxAddr | input | 6 | Address field extracted from the control channel |
| blkValid | input | 1 | Decoded block present |
| blkType | input | 3 | Block type identifier (4 = payload) |
| blkData | input | 16 | Decoded block contents |
| blkCrcOk | input | 1 | Block passed its check |
| endFrame | input | 1 | End frame received |
| hostAck | input | 1 | Host has read the holding register |
| searching | output | 1 | Sync search in progress |
| callActive | output | 1 | Call accepted and not yet finished |
| restartSearch | output | 1 | One-cycle command to restart sync search |
| irqCalled | output | 1 | One-cycle call-accepted interrupt |
| matchCode | output | 2 | 00 open accept, 01 exact, 10 broadcast |
| irqDataReady | output | 1 | Holding register holds unread data |
| irqEvent | output | 1 | One-cycle failed-block interrupt |
| errCode | output | 2 | 01 payload failure, 10 control block failure |
| holdType | output | 3 | Type of the held block |
| holdData | output | 16 | Held block or soft value |
| overrun | output | 1 | Sticky: unread data was overwritten |

## Verification
The assertions assume that `modeRx` is the only way out of a call apart from the flush. They also assume that a new `blkValid` never arrives while a soft-mode payload is still being split into nibbles. For this reason the stimulus spaces payload blocks at least four cycles apart in soft mode. The sync, control-channel and end-frame strobes are assumed to be single-cycle pulses. The directed tasks drive them only for one clock, on the falling edge, so that each one is sampled exactly once.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_FIRST,
    ST_ACTIVE,
    ST_FLUSH
  } callState_t;

  typedef struct packed {
    logic clrAll;
    logic latchMatch;
    logic deliverEn;
    logic dropInc;
    logic dropClr;
  } ctrlStrobe_t;

  localparam logic [1:0] MATCH_NONE  = 2'b00;
  localparam logic [1:0] MATCH_EXACT = 2'b01;
  localparam logic [1:0] MATCH_BCAST = 2'b10;

  localparam logic [1:0] ERR_PAYLOAD = 2'b01;
  localparam logic [1:0] ERR_CONTROL = 2'b10;

endpackage

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_ADDR   = 6,
  parameter int TYPE_W     = 3,
  parameter int BLK_W      = 16,
  parameter int LLR_W      = 4,
  parameter int DROP_W     = 4,
  parameter int PAYLOAD_ID = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strb,
  input  logic                       softMode,
  input  logic [NUM_ADDR*ADDR_W-1:0] ownAddrs,
  input  logic [DROP_W-1:0]          dropLimit,
  input  logic [ADDR_W-1:0]          rxAddr,
  input  logic                       blkValid,
  input  logic [TYPE_W-1:0]          blkType,
  input  logic [BLK_W-1:0]           blkData,
  input  logic                       blkCrcOk,
  input  logic                       hostAck,
  output logic                       addrExact,
  output logic                       addrBcast,
  output logic                       dropExceed,
  output logic                       splitBusy,
  output logic                       readyPend,
  output logic [1:0]                 matchCode,
  output logic                       irqEvent,
  output logic [1:0]                 errCode,
  output logic [TYPE_W-1:0]          holdType,
  output logic [BLK_W-1:0]           holdData,
  output logic                       overrun
);

  localparam int PARTS = BLK_W / LLR_W;
  localparam int CNT_W = (PARTS > 1) ? $clog2(PARTS) : 1;

  logic [NUM_ADDR-1:0] hitVec;
  logic [CNT_W-1:0]    splitCnt;
  logic [BLK_W-1:0]    splitBuf;
  logic [DROP_W-1:0]   dropCnt;
  logic [DROP_W:0]     dropNext;
  logic                isPayload;
  logic                startDel;
  logic                delivery;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ADDR; gi++) begin : g_cmp
      assign hitVec[gi] = (ownAddrs[gi*ADDR_W +: ADDR_W] == rxAddr);
    end
  endgenerate

  assign addrExact  = |hitVec;
  assign addrBcast  = (rxAddr == '0);
  assign isPayload  = (blkType == TYPE_W'(PAYLOAD_ID));
  assign splitBusy  = (splitCnt != '0);
  assign startDel   = strb.deliverEn && blkValid && !splitBusy;
  assign delivery   = startDel || splitBusy;
  assign dropNext   = {1'b0, dropCnt} + (DROP_W+1)'(1);
  assign dropExceed = dropNext > {1'b0, dropLimit};
  assign readyPend  = irqDataReadyQ;

  logic irqDataReadyQ;

  // match type capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchCode <= MATCH_NONE;
    end else if (strb.clrAll) begin
      matchCode <= MATCH_NONE;
    end else if (strb.latchMatch) begin
      matchCode <= addrBcast ? MATCH_BCAST : (addrExact ? MATCH_EXACT : MATCH_NONE);
    end
  end

  // consecutive control-channel failure count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dropCnt <= '0;
    end else if (strb.clrAll || strb.dropClr) begin
      dropCnt <= '0;
    end else if (strb.dropInc) begin
      dropCnt <= dropNext[DROP_W-1:0];
    end
  end

  // holding register, soft split and interrupts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      splitCnt      <= '0;
      splitBuf      <= '0;
      holdType      <= '0;
      holdData      <= '0;
      irqDataReadyQ <= 1'b0;
      irqEvent      <= 1'b0;
      errCode       <= 2'b00;
      overrun       <= 1'b0;
    end else if (strb.clrAll) begin
      splitCnt      <= '0;
      splitBuf      <= '0;
      holdType      <= '0;
      holdData      <= '0;
      irqDataReadyQ <= 1'b0;
      irqEvent      <= 1'b0;
      errCode       <= 2'b00;
      overrun       <= 1'b0;
    end else begin
      irqEvent <= startDel && !blkCrcOk;
      if (delivery) begin
        irqDataReadyQ <= 1'b1;
        if (irqDataReadyQ && !hostAck) overrun <= 1'b1;
      end else if (hostAck) begin
        irqDataReadyQ <= 1'b0;
      end
      if (splitBusy) begin
        holdData <= BLK_W'(splitBuf[LLR_W-1:0]);
        splitBuf <= splitBuf >> LLR_W;
        splitCnt <= splitCnt - CNT_W'(1);
      end else if (startDel) begin
        holdType <= blkType;
        if (!blkCrcOk) errCode <= isPayload ? ERR_PAYLOAD : ERR_CONTROL;
        if (softMode && isPayload && (PARTS > 1)) begin
          holdData <= BLK_W'(blkData[LLR_W-1:0]);
          splitBuf <= blkData >> LLR_W;
          splitCnt <= CNT_W'(PARTS - 1);
        end else begin
          holdData <= blkData;
        end
      end
    end
  end

endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeRx,
  input  logic        openRx,
  input  logic        syncPulse,
  input  logic        ctrlValid,
  input  logic        ctrlCrcOk,
  input  logic        endFrame,
  input  logic        blkValid,
  input  logic        addrExact,
  input  logic        addrBcast,
  input  logic        dropExceed,
  input  logic        splitBusy,
  input  logic        readyPend,
  output ctrlStrobe_t strb,
  output logic        searching,
  output logic        callActive,
  output logic        irqCalled,
  output logic        restartSearch
);

  callState_t st, nxt;
  logic       goSearch;
  logic       called;

  always_comb begin
    nxt         = st;
    strb        = '0;
    goSearch    = 1'b0;
    called      = 1'b0;
    strb.clrAll = !modeRx;
    if (!modeRx) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          nxt      = ST_SEARCH;
          goSearch = 1'b1;
        end
        ST_SEARCH: begin
          if (syncPulse) nxt = ST_FIRST;
        end
        ST_FIRST: begin
          if (ctrlValid && ctrlCrcOk) begin
            if (addrExact || addrBcast || openRx) begin
              nxt             = ST_ACTIVE;
              strb.latchMatch = 1'b1;
              strb.dropClr    = 1'b1;
              called          = 1'b1;
            end else begin
              nxt      = ST_SEARCH;
              goSearch = 1'b1;
            end
          end
        end
        ST_ACTIVE: begin
          strb.deliverEn = 1'b1;
          if (endFrame) begin
            nxt = ST_FLUSH;
          end else if (ctrlValid) begin
            if (ctrlCrcOk)       strb.dropClr = 1'b1;
            else if (dropExceed) nxt          = ST_FLUSH;
            else                 strb.dropInc = 1'b1;
          end
        end
        ST_FLUSH: begin
          strb.deliverEn = 1'b1;
          if (!splitBusy && !readyPend && !blkValid) begin
            nxt      = ST_SEARCH;
            goSearch = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st            <= ST_IDLE;
      irqCalled     <= 1'b0;
      restartSearch <= 1'b0;
    end else begin
      st            <= nxt;
      irqCalled     <= called;
      restartSearch <= goSearch;
    end
  end

  assign searching  = (st == ST_SEARCH);
  assign callActive = (st == ST_ACTIVE) || (st == ST_FLUSH);

endmodule

// File: rtl/rx_call_ctrl.sv
module rx_call_ctrl
  import rcc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_ADDR   = 6,
  parameter int TYPE_W     = 3,
  parameter int BLK_W      = 16,
  parameter int LLR_W      = 4,
  parameter int DROP_W     = 4,
  parameter int PAYLOAD_ID = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modeRx,
  input  logic                       openRx,
  input  logic                       softMode,
  input  logic [NUM_ADDR*ADDR_W-1:0] ownAddrs,
  input  logic [DROP_W-1:0]          dropLimit,
  input  logic                       syncPulse,
  input  logic                       ctrlValid,
  input  logic                       ctrlCrcOk,
  input  logic [ADDR_W-1:0]          rxAddr,
  input  logic                       blkValid,
  input  logic [TYPE_W-1:0]          blkType,
  input  logic [BLK_W-1:0]           blkData,
  input  logic                       blkCrcOk,
  input  logic                       endFrame,
  input  logic                       hostAck,
  output logic                       searching,
  output logic                       callActive,
  output logic                       restartSearch,
  output logic                       irqCalled,
  output logic [1:0]                 matchCode,
  output logic                       irqDataReady,
  output logic                       irqEvent,
  output logic [1:0]                 errCode,
  output logic [TYPE_W-1:0]          holdType,
  output logic [BLK_W-1:0]           holdData,
  output logic                       overrun
);

  ctrlStrobe_t strb;
  logic addrExact, addrBcast, dropExceed, splitBusy, readyPend;

  rcc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeRx(modeRx), .openRx(openRx),
    .syncPulse(syncPulse), .ctrlValid(ctrlValid), .ctrlCrcOk(ctrlCrcOk),
    .endFrame(endFrame), .blkValid(blkValid), .addrExact(addrExact),
    .addrBcast(addrBcast), .dropExceed(dropExceed), .splitBusy(splitBusy),
    .readyPend(readyPend), .strb(strb), .searching(searching),
    .callActive(callActive), .irqCalled(irqCalled), .restartSearch(restartSearch)
  );

  rcc_datapath #(
    .ADDR_W(ADDR_W), .NUM_ADDR(NUM_ADDR), .TYPE_W(TYPE_W), .BLK_W(BLK_W),
    .LLR_W(LLR_W), .DROP_W(DROP_W), .PAYLOAD_ID(PAYLOAD_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .softMode(softMode),
    .ownAddrs(ownAddrs), .dropLimit(dropLimit), .rxAddr(rxAddr),
    .blkValid(blkValid), .blkType(blkType), .blkData(blkData),
    .blkCrcOk(blkCrcOk), .hostAck(hostAck), .addrExact(addrExact),
    .addrBcast(addrBcast), .dropExceed(dropExceed), .splitBusy(splitBusy),
    .readyPend(readyPend), .matchCode(matchCode), .irqEvent(irqEvent),
    .errCode(errCode), .holdType(holdType), .holdData(holdData),
    .overrun(overrun)
  );

  assign irqDataReady = readyPend;

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       modeRx,
  input logic       openRx,
  input logic       searching,
  input logic       callActive,
  input logic       restartSearch,
  input logic       irqCalled,
  input logic [1:0] matchCode,
  input logic       irqDataReady,
  input logic       irqEvent,
  input logic       overrun
);

  AST_IDLE_NEXT_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !modeRx |=> (!searching && !callActive && !irqDataReady && !overrun)); // R13

  AST_RESTART_IN_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    restartSearch |-> searching); // R6

  AST_CALLED_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(callActive) |-> irqCalled); // R4

  AST_CALLED_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqCalled |=> !irqCalled); // R4

  AST_CALLED_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (irqCalled && !$past(openRx)) |-> (matchCode != MATCH_NONE)); // R6

  AST_EVENT_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    irqEvent |-> irqDataReady); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && modeRx) |=> overrun); // R9

endmodule

bind rx_call_ctrl rcc_checker chk_i (
  .clk(clk), .rstN(rstN), .modeRx(modeRx), .openRx(openRx),
  .searching(searching), .callActive(callActive),
  .restartSearch(restartSearch), .irqCalled(irqCalled),
  .matchCode(matchCode), .irqDataReady(irqDataReady),
  .irqEvent(irqEvent), .overrun(overrun)
);

// File: tb/rx_call_ctrl_tb_top.sv
module rx_call_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeRx, openRx, softMode;
  logic [35:0] ownAddrs;
  logic [3:0]  dropLimit;
  logic        syncPulse, ctrlValid, ctrlCrcOk;
  logic [5:0]  rxAddr;
  logic        blkValid;
  logic [2:0]  blkType;
  logic [15:0] blkData;
  logic        blkCrcOk, endFrame, hostAck;
  logic        searching, callActive, restartSearch, irqCalled;
  logic [1:0]  matchCode;
  logic        irqDataReady, irqEvent;
  logic [1:0]  errCode;
  logic [2:0]  holdType;
  logic [15:0] holdData;
  logic        overrun;

  int nTests = 0;
  int nFail  = 0;

  logic [5:0] addrTab [6] = '{6'h11, 6'h22, 6'h2A, 6'h15, 6'h3F, 6'h07};

  always #2 clk = ~clk;

  rx_call_ctrl dut_i (
    .clk(clk), .rstN(rstN), .modeRx(modeRx), .openRx(openRx),
    .softMode(softMode), .ownAddrs(ownAddrs), .dropLimit(dropLimit),
    .syncPulse(syncPulse), .ctrlValid(ctrlValid), .ctrlCrcOk(ctrlCrcOk),
    .rxAddr(rxAddr), .blkValid(blkValid), .blkType(blkType),
    .blkData(blkData), .blkCrcOk(blkCrcOk), .endFrame(endFrame),
    .hostAck(hostAck), .searching(searching), .callActive(callActive),
    .restartSearch(restartSearch), .irqCalled(irqCalled),
    .matchCode(matchCode), .irqDataReady(irqDataReady),
    .irqEvent(irqEvent), .errCode(errCode), .holdType(holdType),
    .holdData(holdData), .overrun(overrun)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic goIdle();
    modeRx = 1'b0;
    cyc();
  endtask

  // from idle: search, sync, good control channel with given address
  task automatic openCall(input logic [5:0] addr);
    goIdle();
    modeRx = 1'b1;
    cyc();
    syncPulse = 1'b1;
    cyc();
    syncPulse = 1'b0;
    ctrlValid = 1'b1; ctrlCrcOk = 1'b1; rxAddr = addr;
    cyc();
    ctrlValid = 1'b0;
  endtask

  task automatic sendBlk(input logic [2:0] t, input logic [15:0] d, input logic ok);
    blkValid = 1'b1; blkType = t; blkData = d; blkCrcOk = ok;
    cyc();
    blkValid = 1'b0; blkCrcOk = 1'b1;
  endtask

  task automatic ctrlFrame(input logic ok);
    ctrlValid = 1'b1; ctrlCrcOk = ok;
    cyc();
    ctrlValid = 1'b0; ctrlCrcOk = 1'b1;
  endtask

  task automatic testReset();
    chk("R1", "searching in reset", searching, 0);
    chk("R1", "callActive in reset", callActive, 0);
    rstN = 1'b1;
    cyc();
    chk("R1", "ready after reset", irqDataReady, 0);
    chk("R1", "overrun after reset", overrun, 0);
    modeRx = 1'b1;
    cyc();
    chk("R1", "searching on entry", searching, 1);
    chk("R1", "restart pulse", restartSearch, 1);
    cyc();
    chk("R1", "restart single", restartSearch, 0);
  endtask

  task automatic testRescan();
    syncPulse = 1'b1;
    cyc();
    syncPulse = 1'b0;
    chk("R2", "left search", searching, 0);
    chk("R2", "not yet active", callActive, 0);
    rxAddr = addrTab[0];
    ctrlFrame(1'b0);
    chk("R3", "bad crc ignored active", callActive, 0);
    chk("R3", "bad crc no search", searching, 0);
    ctrlFrame(1'b0);
    chk("R3", "second bad crc ignored", callActive, 0);
    ctrlFrame(1'b1);
    chk("R3", "later good frame accepted", callActive, 1);
    chk("R4", "called pulse", irqCalled, 1);
    cyc();
    chk("R4", "called single", irqCalled, 0);
  endtask

  task automatic testExact();
    for (int i = 0; i < 6; i++) begin
      openCall(addrTab[i]);
      chk("R4", $sformatf("entry %0d active", i), callActive, 1);
      chk("R4", $sformatf("entry %0d code", i), matchCode, 1);
    end
  endtask

  task automatic testBcastReject();
    openCall(6'h00);
    chk("R5", "broadcast active", callActive, 1);
    chk("R5", "broadcast code", matchCode, 2);
    openCall(6'h01);
    chk("R6", "reject not active", callActive, 0);
    chk("R6", "reject searching", searching, 1);
    chk("R6", "reject restart", restartSearch, 1);
    openRx = 1'b1;
    openCall(6'h01);
    chk("R6", "open accept", callActive, 1);
    chk("R6", "open code", matchCode, 0);
    openRx = 1'b0;
  endtask

  task automatic testBlocks();
    openCall(addrTab[1]);
    sendBlk(3'd2, 16'h1234, 1'b1);
    chk("R7", "ready set", irqDataReady, 1);
    chk("R7", "type", holdType, 2);
    chk("R7", "data", holdData, 16'h1234);
    chk("R8", "no event on good", irqEvent, 0);
    hostAck = 1'b1;
    cyc();
    hostAck = 1'b0;
    chk("R7", "ready cleared", irqDataReady, 0);
    sendBlk(3'd4, 16'h55AA, 1'b0);
    chk("R8", "event payload", irqEvent, 1);
    chk("R8", "ready with event", irqDataReady, 1);
    chk("R8", "err payload", errCode, 1);
    hostAck = 1'b1;
    cyc();
    hostAck = 1'b0;
    chk("R8", "event single", irqEvent, 0);
    sendBlk(3'd1, 16'h0F0F, 1'b0);
    chk("R8", "err control", errCode, 2);
    chk("R9", "no overrun yet", overrun, 0);
    sendBlk(3'd2, 16'hBEEF, 1'b1);
    chk("R9", "overrun set", overrun, 1);
    chk("R9", "overwritten", holdData, 16'hBEEF);
    hostAck = 1'b1;
    cyc(); cyc();
    hostAck = 1'b0;
    chk("R9", "overrun sticky", overrun, 1);
    goIdle();
    chk("R13", "overrun cleared", overrun, 0);
    chk("R13", "match cleared", matchCode, 0);
  endtask

  task automatic testSoft();
    openCall(addrTab[2]);
    softMode = 1'b1;
    hostAck  = 1'b1;
    sendBlk(3'd4, 16'hA5C3, 1'b1);
    chk("R10", "nibble0", holdData, 16'h0003);
    chk("R10", "ready0", irqDataReady, 1);
    cyc();
    chk("R10", "nibble1", holdData, 16'h000C);
    cyc();
    chk("R10", "nibble2", holdData, 16'h0005);
    cyc();
    chk("R10", "nibble3", holdData, 16'h000A);
    chk("R10", "ready3", irqDataReady, 1);
    cyc();
    chk("R10", "ready cleared after split", irqDataReady, 0);
    chk("R10", "no overrun with ack", overrun, 0);
    sendBlk(3'd2, 16'h0BEE, 1'b1);
    chk("R10", "non payload whole", holdData, 16'h0BEE);
    cyc();
    hostAck = 1'b0;
    softMode = 1'b0;
  endtask

  task automatic testDrop();
    dropLimit = 4'd2;
    openCall(addrTab[3]);
    ctrlFrame(1'b0); ctrlFrame(1'b0); ctrlFrame(1'b1);
    ctrlFrame(1'b0); ctrlFrame(1'b0);
    chk("R11", "good frame reset count", callActive, 1);
    ctrlFrame(1'b0);
    chk("R11", "flush after threshold", callActive, 1);
    cyc();
    chk("R11", "call ended", callActive, 0);
    chk("R12", "search after drop", searching, 1);
    chk("R12", "restart after drop", restartSearch, 1);
  endtask

  task automatic testEnd();
    openCall(addrTab[4]);
    endFrame = 1'b1;
    sendBlk(3'd2, 16'h7777, 1'b1);
    endFrame = 1'b0;
    chk("R12", "final block held", holdData, 16'h7777);
    cyc();
    chk("R12", "waits for host", callActive, 1);
    hostAck = 1'b1;
    cyc();
    hostAck = 1'b0;
    chk("R12", "acked", irqDataReady, 0);
    chk("R12", "still flushing", callActive, 1);
    cyc();
    chk("R12", "ended", callActive, 0);
    chk("R12", "search restarted", searching, 1);
    chk("R12", "restart pulse", restartSearch, 1);
  endtask

  task automatic testIdleMid();
    openCall(addrTab[5]);
    sendBlk(3'd2, 16'h4444, 1'b1);
    modeRx = 1'b0;
    cyc();
    chk("R13", "idle no call", callActive, 0);
    chk("R13", "idle no search", searching, 0);
    chk("R13", "idle ready cleared", irqDataReady, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeRx = 1'b0; openRx = 1'b0; softMode = 1'b0;
    for (int i = 0; i < 6; i++) ownAddrs[i*6 +: 6] = addrTab[i];
    dropLimit = 4'd3; syncPulse = 1'b0; ctrlValid = 1'b0; ctrlCrcOk = 1'b1;
    rxAddr = 6'h0; blkValid = 1'b0; blkType = 3'd0; blkData = 16'h0;
    blkCrcOk = 1'b1; endFrame = 1'b0; hostAck = 1'b0;
    cyc(); cyc();
    testReset();
    testRescan();
    testExact();
    testBcastReject();
    testBlocks();
    testSoft();
    testDrop();
    testEnd();
    testIdleMid();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule